// File: doc/BRIEF.md
# Self-Clocked Converter Frame Receiver

This block sits on the host side of a serial link to a delta-sigma converter that produces its own serial clock. The host owns only the active-low select line; the converter answers a falling select by holding its clock low and showing a ready flag on its data line. A low flag means a result is waiting. If select then stays low, the converter starts clocking on its own after a fixed test delay. The host either takes the whole frame, cuts it short, or releases select before the delay to leave the converter asleep with its result held.

The receiver brings the incoming clock and data into the system clock through two-flop synchronizers. It finds rising serial-clock edges in the system domain and shifts in one bit per edge, MSB first, until the frame length is reached. A `start_i` pulse begins a transaction. `check_only_i` picks a flag probe that releases select early. `abort_len_i` picks an early stop after that many bits. A timer reports a stalled link if no clock edge comes after the flag reads ready.

Top module: `adc_frame_rx`

## Requirements
- R1: After reset `cs_n_o` is 1 and `word_valid_o`, `aborted_o`, `timeout_o` and `flag_valid_o` are 0.
- R2: A `start_i` pulse while idle with `check_only_i`=1 drives `cs_n_o` low for CHECK_CYC cycles, samples the synchronized data line, then raises `cs_n_o`. In the same cycle it pulses `flag_valid_o` with `flag_busy_o` equal to the sampled level: 1 means converting, 0 means ready. No serial clock edge is requested, because CHECK_CYC is shorter than the converter's test delay.
- R3: In a normal read, each synchronized rising serial-clock edge shifts in one data bit, MSB first. After FRAME_BITS (32) edges, `word_valid_o` pulses for one cycle and `word_o` holds the frame, whose bit 31 is the ready flag (0). `cs_n_o` is high in the same cycle.
- R4: During a normal read, `cs_n_o` stays low from the start until the frame's end pulse.
- R5: An `abort_len_i` value N with 1 <= N < FRAME_BITS, latched at start, raises `cs_n_o` after the Nth rising edge. `aborted_o` then pulses, and `word_o` holds the N received bits right-aligned with zeros above. `word_valid_o` does not pulse.
- R6: An `abort_len_i` of 0 or of FRAME_BITS and above gives a full frame (R3).
- R7: While the synchronized data line reads 1 (converting), the receiver keeps `cs_n_o` low and waits. The frame that follows once the flag falls is received correctly, however long the conversion lasts.
- R8: If the data line reads 0 and no rising serial-clock edge arrives within TIMEOUT_CYC cycles, `timeout_o` pulses and `cs_n_o` returns high.
- R9: A `start_i` pulse during a transaction is ignored, and the frame in progress completes unchanged.
- R10: At most one of `word_valid_o`, `aborted_o`, `timeout_o` and `flag_valid_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transaction (sampled when idle) |
| check_only_i | input | 1 | 1: probe the flag and release select early |
| abort_len_i | input | 6 | Bits to receive before aborting; 0 means full frame |
| sclk_i | input | 1 | Serial clock driven by the converter |
| sdo_i | input | 1 | Serial data / ready flag from the converter |
| cs_n_o | output | 1 | Active-low select to the converter |
| word_o | output | 32 | Received bits, right-aligned |
| word_valid_o | output | 1 | One-cycle pulse: full frame received |
| aborted_o | output | 1 | One-cycle pulse: frame cut short by abort length |
| timeout_o | output | 1 | One-cycle pulse: no clock edge after ready flag |
| flag_valid_o | output | 1 | One-cycle pulse: check-only flag sample done |
| flag_busy_o | output | 1 | Sampled flag level (1 = converting) |

## Verification
The assertions take for granted that the serial clock is at least eight times slower than the system clock. They also assume the data line changes only on falling serial-clock edges, so it is settled whenever a rising edge is detected. The converter model in the bench holds each serial-clock phase for four system cycles and changes data only while the clock is low. Its test delay of 40 cycles is well above the check window, so every sampled bit and flag comes from a stable level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    // Receiver control states
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETTLE = 2'd1,
        S_WAIT   = 2'd2,
        S_DATA   = 2'd3
    } rxf_state_e;
endpackage

// File: rtl/rxf_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs, with a rising
// edge detector on every bit. Assumes each input holds a level for more than
// two system clock cycles.
module rxf_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stg1_q, stg2_q, prev_q;

    // Two-stage capture plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= '1;
            stg2_q <= '1;
            prev_q <= '1;
        end else begin
            stg1_q <= async_i;
            stg2_q <= stg1_q;
            prev_q <= stg2_q;
        end
    end

    assign level_o = stg2_q;
    assign rise_o  = stg2_q & ~prev_q;
endmodule

// File: rtl/rxf_shift.sv
// MSB-first shift register with a bit counter. Clear empties both; each
// shift moves the register left and appends the new bit at the LSB.
module rxf_shift #(
    parameter int W     = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [W-1:0]     data_o,
    output logic [CNT_W-1:0] cnt_o
);
    // Shift register and bit count update
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else if (shift_i) begin
            data_o <= {data_o[W-2:0], bit_i};
            cnt_o  <= cnt_o + 1'b1;
        end
    end

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(W));
endmodule

// File: rtl/rxf_ctrl.sv
// Transaction controller: owns select, settles after select falls, probes
// or waits for the ready flag, counts bits and ends the frame on full length,
// abort length or timeout. Assumes synchronized inputs and one-cycle edges.
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int FRAME_BITS  = 32,
    parameter int CNT_W       = 6,
    parameter int CHECK_CYC   = 6,
    parameter int TIMEOUT_CYC = 200,
    parameter int TMR_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             check_only_i,
    input  logic [CNT_W-1:0] abort_len_i,
    input  logic             sdo_s_i,
    input  logic             sclk_rise_i,
    input  logic [CNT_W-1:0] bit_cnt_i,
    output logic             clear_o,
    output logic             shift_o,
    output logic             cs_n_o,
    output logic             word_valid_o,
    output logic             aborted_o,
    output logic             timeout_o,
    output logic             flag_valid_o,
    output logic             flag_busy_o
);
    rxf_state_e       state_q;
    logic             check_q;
    logic [CNT_W-1:0] abort_q;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             take_bit;

    assign take_bit = sclk_rise_i && (state_q == S_WAIT || state_q == S_DATA);
    assign cnt_nxt  = bit_cnt_i + 1'b1;
    assign clear_o  = (state_q == S_IDLE) && start_i;
    assign shift_o  = take_bit;

    // State machine, select line, timers and result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            check_q      <= 1'b0;
            abort_q      <= '0;
            tmr_q        <= '0;
            cs_n_o       <= 1'b1;
            word_valid_o <= 1'b0;
            aborted_o    <= 1'b0;
            timeout_o    <= 1'b0;
            flag_valid_o <= 1'b0;
            flag_busy_o  <= 1'b0;
        end else begin
            word_valid_o <= 1'b0;
            aborted_o    <= 1'b0;
            timeout_o    <= 1'b0;
            flag_valid_o <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        cs_n_o  <= 1'b0;
                        check_q <= check_only_i;
                        abort_q <= abort_len_i;
                        tmr_q   <= '0;
                        state_q <= S_SETTLE;
                    end
                end
                S_SETTLE: begin
                    if (tmr_q == TMR_W'(CHECK_CYC - 1)) begin
                        tmr_q <= '0;
                        if (check_q) begin
                            flag_valid_o <= 1'b1;
                            flag_busy_o  <= sdo_s_i;
                            cs_n_o       <= 1'b1;
                            state_q      <= S_IDLE;
                        end else begin
                            state_q <= S_WAIT;
                        end
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: begin
                    if (take_bit) begin
                        state_q <= S_DATA;
                        if (cnt_nxt == CNT_W'(FRAME_BITS)) begin
                            word_valid_o <= 1'b1;
                            cs_n_o       <= 1'b1;
                            state_q      <= S_IDLE;
                        end else if (abort_q != '0 && cnt_nxt == abort_q) begin
                            aborted_o <= 1'b1;
                            cs_n_o    <= 1'b1;
                            state_q   <= S_IDLE;
                        end
                    end else if (state_q == S_WAIT) begin
                        if (sdo_s_i) begin
                            tmr_q <= '0;
                        end else if (tmr_q == TMR_W'(TIMEOUT_CYC - 1)) begin
                            timeout_o <= 1'b1;
                            cs_n_o    <= 1'b1;
                            state_q   <= S_IDLE;
                        end else begin
                            tmr_q <= tmr_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_valid_o, aborted_o, timeout_o, flag_valid_o}));
    a_r3_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (bit_cnt_i == CNT_W'(FRAME_BITS)) && cs_n_o);
    a_r5_abort_count: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |-> (bit_cnt_i == abort_q) && (bit_cnt_i < CNT_W'(FRAME_BITS)));
    a_r4_cs_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA || state_q == S_WAIT) |-> !cs_n_o);
    a_r8_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> cs_n_o && (bit_cnt_i == '0));
    a_r2_flag_in_check: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid_o |-> check_q && cs_n_o && (bit_cnt_i == '0));
endmodule

// File: rtl/adc_frame_rx.sv
// Host-side receiver for a converter that clocks its own serial output.
// Synchronizes clock and data, controls select, and assembles the frame.
// Assumes the system clock is at least 8x the serial clock rate.
module adc_frame_rx #(
    parameter int FRAME_BITS  = 32,
    parameter int CHECK_CYC   = 6,
    parameter int TIMEOUT_CYC = 200,
    parameter int CNT_W       = $clog2(FRAME_BITS + 1),
    parameter int TMR_MAX     = (TIMEOUT_CYC > CHECK_CYC) ? TIMEOUT_CYC : CHECK_CYC,
    parameter int TMR_W       = $clog2(TMR_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  check_only_i,
    input  logic [CNT_W-1:0]      abort_len_i,
    input  logic                  sclk_i,
    input  logic                  sdo_i,
    output logic                  cs_n_o,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  word_valid_o,
    output logic                  aborted_o,
    output logic                  timeout_o,
    output logic                  flag_valid_o,
    output logic                  flag_busy_o
);
    logic [1:0]       lvl, rise;
    logic             clear, shift;
    logic [CNT_W-1:0] bit_cnt;

    rxf_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdo_i, sclk_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    rxf_shift #(.W(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .shift_i (shift),
        .bit_i   (lvl[1]),
        .data_o  (word_o),
        .cnt_o   (bit_cnt)
    );

    rxf_ctrl #(
        .FRAME_BITS  (FRAME_BITS),
        .CNT_W       (CNT_W),
        .CHECK_CYC   (CHECK_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .TMR_W       (TMR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .check_only_i (check_only_i),
        .abort_len_i  (abort_len_i),
        .sdo_s_i      (lvl[1]),
        .sclk_rise_i  (rise[0]),
        .bit_cnt_i    (bit_cnt),
        .clear_o      (clear),
        .shift_o      (shift),
        .cs_n_o       (cs_n_o),
        .word_valid_o (word_valid_o),
        .aborted_o    (aborted_o),
        .timeout_o    (timeout_o),
        .flag_valid_o (flag_valid_o),
        .flag_busy_o  (flag_busy_o)
    );
endmodule

// File: tb/adc_frame_rx_tb.sv
module adc_frame_rx_tb;
    localparam int FB = 32;
    localparam int HALF = 4;
    localparam int T_TEST = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, chk = 1'b0;
    logic [5:0] alen = '0;
    logic sclk = 1'b1, sdo = 1'b1;
    logic cs_n;
    logic [31:0] word;
    logic wv, ab, to, fv, fb;

    int checks = 0, fails = 0, rises = 0;
    int busy_len = 0;
    bit mute = 0, done = 0;
    logic [31:0] frame = '0;

    always #10 clk = ~clk;

    adc_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .check_only_i(chk),
        .abort_len_i(alen), .sclk_i(sclk), .sdo_i(sdo), .cs_n_o(cs_n),
        .word_o(word), .word_valid_o(wv), .aborted_o(ab), .timeout_o(to),
        .flag_valid_o(fv), .flag_busy_o(fb)
    );

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Converter model: one select-low session per call
    task automatic dev_session();
        sclk = 1'b0;
        sdo = (busy_len > 0);
        for (int i = 0; i < busy_len; i++) begin
            @(negedge clk);
            if (cs_n) begin sclk = 1'b1; sdo = 1'b1; return; end
        end
        sdo = 1'b0;
        for (int i = 0; i < T_TEST; i++) begin
            @(negedge clk);
            if (cs_n) begin sclk = 1'b1; sdo = 1'b1; return; end
        end
        if (mute) begin
            while (!cs_n) @(negedge clk);
            sclk = 1'b1; sdo = 1'b1; return;
        end
        for (int b = FB - 1; b >= 0; b--) begin
            sdo = frame[b];
            for (int i = 0; i < HALF; i++) begin
                @(negedge clk);
                if (cs_n) begin sclk = 1'b1; sdo = 1'b1; return; end
            end
            sclk = 1'b1; rises++;
            for (int i = 0; i < HALF; i++) begin
                @(negedge clk);
                if (cs_n) begin sdo = 1'b1; return; end
            end
            if (b > 0) sclk = 1'b0;
        end
        sdo = 1'b1;
        while (!cs_n) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !cs_n) dev_session();
        end
    end

    // Run one transaction; returns which pulse ended it
    task automatic run(input bit c, input logic [5:0] n, input bit extra_start,
                       output int kind, output logic [31:0] w, output logic flag, output int cs_hi);
        kind = 0; cs_hi = 0; w = '0; flag = 1'b0;
        @(negedge clk);
        chk = c; alen = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            if (extra_start && t == 100) start = 1'b1;
            if (extra_start && t == 101) start = 1'b0;
            if (wv) kind = 1; else if (ab) kind = 2; else if (to) kind = 3; else if (fv) kind = 4;
            if (kind != 0) begin w = word; flag = fb; break; end
            if (cs_n) cs_hi++;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int k, hi, r0;
        logic [31:0] w, pay;
        logic f;
        repeat (3) @(negedge clk);
        chk_eq("R1 cs_n", cs_n, 1);
        chk_eq("R1 pulses", {wv, ab, to, fv}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R4: full frames over several payloads
        for (int p = 0; p < 4; p++) begin
            pay = 32'h1357_9BDF * (p + 3) ^ (32'hF0F0_0F0F >> p);
            frame = {1'b0, pay[30:0]};
            busy_len = 0;
            run(0, 0, 0, k, w, f, hi);
            chk_eq("R3 kind", k, 1);
            chk_eq("R3 word", w, frame);
            chk_eq("R4 cs_n low", hi, 0);
        end

        // R5/R6: sweep every abort length
        for (int n = 1; n <= 33; n++) begin
            frame = {1'b0, 31'h5A3C_96E1 ^ 31'(n * 32'h0101_0101)};
            run(0, 6'(n), 0, k, w, f, hi);
            if (n < FB) begin
                chk_eq("R5 kind", k, 2);
                chk_eq("R5 word", w, frame >> (FB - n));
            end else begin
                chk_eq("R6 kind", k, 1);
                chk_eq("R6 word", w, frame);
            end
        end

        // R2: check-only probe, ready then busy; no clock edge requested
        frame = 32'h0123_4567;
        r0 = rises;
        busy_len = 0;
        run(1, 0, 0, k, w, f, hi);
        chk_eq("R2 kind ready", k, 4);
        chk_eq("R2 flag ready", f, 0);
        chk_eq("R2 no clock", rises, r0);
        chk_eq("R2 cs_n released", cs_n, 1);
        busy_len = 50;
        run(1, 0, 0, k, w, f, hi);
        chk_eq("R2 kind busy", k, 4);
        chk_eq("R2 flag busy", f, 1);
        chk_eq("R2 no clock busy", rises, r0);

        // R7: long conversion, longer than the timeout window
        busy_len = 300;
        frame = 32'h7ACE_1234;
        run(0, 0, 0, k, w, f, hi);
        chk_eq("R7 kind", k, 1);
        chk_eq("R7 word", w, frame);
        busy_len = 0;

        // R9: second start mid-frame has no effect
        frame = 32'h3C3C_A5A5;
        run(0, 0, 1, k, w, f, hi);
        chk_eq("R9 kind", k, 1);
        chk_eq("R9 word", w, frame);
        chk_eq("R9 cs_n low", hi, 0);

        // R8: converter never clocks
        mute = 1;
        run(0, 0, 0, k, w, f, hi);
        chk_eq("R8 kind", k, 3);
        chk_eq("R8 cs_n", cs_n, 1);
        mute = 0;

        // R10: pulses stay exclusive over an extra frame
        frame = 32'h0F1E_2D3C;
        run(0, 0, 0, k, w, f, hi);
        chk_eq("R10 kind", k, 1);
        chk_eq("R10 after", {wv, ab, to, fv}, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule